// File: doc/BRIEF.md
# Burst-Drain Byte Buffer to Serial Transmitter

This block sits between a fast byte source and a slow asynchronous serial line. Bytes come in on a valid/ready port and are stored in a small FIFO. The buffer is not drained byte by byte. When the FIFO reports full, the block enters a drain interval. In that interval the serial transmitter pops one byte per frame and keeps popping until the FIFO reports empty. The write side is held off for the whole interval. The byte source can therefore fill the buffer at its own high rate, pause while the slow line catches up, and then resume.

The FIFO exposes its full and empty flags as active-low outputs. A separate pause output tells the upstream controller to stop producing. The input port states back-pressure through its ready signal:
- A byte transfers on a clock edge where `in_valid` and `in_ready` are both high.
- While `in_ready` is low, the source may hold `in_valid` high with any data, and nothing is taken.
- The source does not have to keep its data stable while it waits.

At the end of a transfer the FIFO may hold fewer bytes than its depth. A `flush` pulse then starts a drain of whatever is stored, without waiting for the FIFO to fill.

Top module: `fifo_uart_drain`

## Requirements
- R1: After reset:
  - `tx` is 1.
  - `empty_n` is 0 and `full_n` is 1.
  - `wr_pause` is 0 and `in_ready` is 1.
- R2: A byte is stored on each clock edge where `in_valid` and `in_ready` are both 1. `empty_n` reads 1 from the cycle after the first stored byte.
- R3: When DEPTH bytes are stored, `full_n` reads 0 and `in_ready` reads 0. `wr_pause` reads 1 from the next cycle.
- R4: With fewer than DEPTH bytes stored and no `flush`, no drain happens:
  - `wr_pause` stays 0.
  - `tx` stays 1.
- R5: While `wr_pause` is 1, `in_ready` is 0. A byte offered on the input while `in_ready` is 0 is never stored and never transmitted.
- R6: Each byte is sent as one frame. The line idles at 1. A frame is:
  - one start bit of 0;
  - eight data bits, least significant bit first;
  - one stop bit of 1.

  Every bit lasts BAUD_DIV clock cycles.
- R7: A drain sends the stored bytes in the order they were written. It sends exactly as many frames as there were stored bytes.
- R8: A drain ends once the FIFO is empty. After that, `wr_pause` is 0, `empty_n` is 0 and `in_ready` is 1.
- R9: Flush behaviour depends on whether the FIFO holds data:
  - A one-cycle `flush` while the FIFO holds at least one byte sets `wr_pause` to 1 in the next cycle, and the stored bytes are drained.
  - A `flush` while the FIFO is empty leaves `wr_pause` at 0 and sends nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Source offers a byte |
| in_data | input | DATA_W | Offered byte |
| in_ready | output | 1 | Buffer accepts a byte this cycle |
| flush | input | 1 | Start a drain of a partly filled buffer |
| full_n | output | 1 | Buffer holds DEPTH bytes, active low |
| empty_n | output | 1 | Buffer holds no byte, active low |
| wr_pause | output | 1 | Drain interval in progress; source should hold off |
| tx | output | 1 | Serial output line |

## Verification
The hardest condition to reach is a source that keeps pushing while the block is paused. It must be shown that no such byte gets in, including around the cycle where the pause releases. The stimulus holds `in_valid` high with a marker value for the whole drain interval. It checks `wr_pause` at every falling edge and drops `in_valid` before the first edge where `in_ready` could be high again. It then checks that the marker never appears on the line. The partial-burst path is swept over every fill level below the depth: the bench waits long enough to prove that no drain begins on its own, then flushes and decodes the frames.

// File: rtl/fifo_uart_pkg.sv
package fifo_uart_pkg;
  localparam int FRAME_BITS = 10;
  typedef enum logic {
    TX_IDLE  = 1'b0,
    TX_SHIFT = 1'b1
  } tx_state_t;
endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full_n,
  output logic         empty_n
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_wr, do_rd;

  assign do_wr   = wr_en && (count != FULL_CNT);
  assign do_rd   = rd_en && (count != '0);
  assign full_n  = (count != FULL_CNT);
  assign empty_n = (count != '0);
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/drain_ctrl.sv
module drain_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic full_n,
  input  logic empty_n,
  input  logic flush,
  output logic draining
);
  logic start_drain;

  // A full buffer, or a flush request while holding data, opens the interval.
  assign start_drain = !full_n || (flush && empty_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      draining <= 1'b0;
    end else if (!draining) begin
      draining <= start_drain;
    end else if (!empty_n) begin
      draining <= 1'b0;
    end
  end
endmodule

// File: rtl/baud_tick.sv
module baud_tick #(
  parameter int DIV = 5208
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || !run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import fifo_uart_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BAUD_DIV = 5208
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  output logic              idle,
  output logic              tx
);
  localparam int SW = DATA_W + 2;
  localparam int BW = $clog2(SW);
  localparam logic [BW-1:0] LAST_BIT = BW'(SW - 1);

  tx_state_t     state;
  logic [SW-1:0] shreg;
  logic [BW-1:0] bit_idx;
  logic          tick;

  baud_tick #(.DIV(BAUD_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state == TX_SHIFT),
    .restart (load),
    .tick    (tick)
  );

  assign idle = (state == TX_IDLE);
  assign tx   = shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= TX_IDLE;
      shreg   <= '1;
      bit_idx <= '0;
    end else if (load && idle) begin
      state   <= TX_SHIFT;
      shreg   <= {1'b1, data, 1'b0};
      bit_idx <= '0;
    end else if (tick) begin
      shreg   <= {1'b1, shreg[SW-1:1]};
      bit_idx <= bit_idx + 1'b1;
      if (bit_idx == LAST_BIT) state <= TX_IDLE;
    end
  end
endmodule

// File: rtl/fifo_uart_drain.sv
module fifo_uart_drain
  import fifo_uart_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 8,
  parameter int BAUD_DIV = 5208
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              flush,
  output logic              full_n,
  output logic              empty_n,
  output logic              wr_pause,
  output logic              tx
);
  logic              draining;
  logic              tx_idle;
  logic              pop;
  logic [DATA_W-1:0] head;

  assign in_ready = full_n && !draining;
  assign wr_pause = draining;
  assign pop      = draining && empty_n && tx_idle;

  fifo_store #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (in_valid && in_ready),
    .wr_data (in_data),
    .rd_en   (pop),
    .rd_data (head),
    .full_n  (full_n),
    .empty_n (empty_n)
  );

  drain_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .full_n   (full_n),
    .empty_n  (empty_n),
    .flush    (flush),
    .draining (draining)
  );

  serial_tx #(.DATA_W(DATA_W), .BAUD_DIV(BAUD_DIV)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (pop),
    .data  (head),
    .idle  (tx_idle),
    .tx    (tx)
  );
endmodule

// File: rtl/fifo_uart_drain_chk.sv
module fifo_uart_drain_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic flush,
  input logic full_n,
  input logic empty_n,
  input logic wr_pause
);
  // R3
  full_starts_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |=> wr_pause);

  // R4
  no_self_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_pause && full_n && !flush) |=> !wr_pause);

  // R5
  paused_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pause && in_valid) |=> !$rose(empty_n));

  // R8
  drain_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pause && !empty_n) |=> !wr_pause);

  // R9
  flush_starts_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && empty_n && !wr_pause) |=> wr_pause);

  // R9
  flush_empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !empty_n && !wr_pause) |=> !wr_pause);
endmodule

bind fifo_uart_drain fifo_uart_drain_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .flush    (flush),
  .full_n   (full_n),
  .empty_n  (empty_n),
  .wr_pause (wr_pause)
);

// File: tb/fifo_uart_drain_bench.sv
`timescale 1ns/1ps
module fifo_uart_drain_bench;
  localparam int DW    = 8;
  localparam int DEP   = 4;
  localparam int DIV   = 4;
  localparam int FRAME = 10 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic flush = 1'b0;
  logic in_ready, full_n, empty_n, wr_pause, tx;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [DW-1:0] rx_mem [64];
  int rx_cnt = 0;
  logic [DW-1:0] exp_mem [64];
  int exp_cnt = 0;

  always #2.5 clk = ~clk;

  fifo_uart_drain #(.DATA_W(DW), .DEPTH(DEP), .BAUD_DIV(DIV)) u_fifo_uart_drain (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .flush(flush), .full_n(full_n), .empty_n(empty_n),
    .wr_pause(wr_pause), .tx(tx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Frame decoder sampled on falling edges at bit centres (R6).
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx == 1'b0) begin
        logic [DW-1:0] b;
        logic bad_start, bad_stop;
        b = '0;
        repeat (DIV / 2) @(negedge clk);
        bad_start = (tx != 1'b0);
        for (int i = 0; i < DW; i++) begin
          repeat (DIV) @(negedge clk);
          b[i] = tx;
        end
        repeat (DIV) @(negedge clk);
        bad_stop = (tx != 1'b1);
        check(!bad_start, "R6 start bit", int'(bad_start), 0);
        check(!bad_stop, "R6 stop bit", int'(bad_stop), 0);
        if (rx_cnt < 64) rx_mem[rx_cnt] = b;
        rx_cnt++;
      end
    end
  end

  task automatic put(input logic [DW-1:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    exp_mem[exp_cnt] = d;
    exp_cnt++;
  endtask

  task automatic wait_frames(input int n);
    int guard = 0;
    while (rx_cnt < n && guard < (n + 2) * FRAME * 2) begin
      @(negedge clk);
      guard++;
    end
    check(rx_cnt == n, "R7 frame count", rx_cnt, n);
  endtask

  task automatic compare_all();
    for (int i = 0; i < exp_cnt && i < rx_cnt; i++)
      check(rx_mem[i] == exp_mem[i], "R7 byte order", int'(rx_mem[i]), int'(exp_mem[i]));
  endtask

  task automatic expect_drained();
    repeat (DIV) @(negedge clk);
    check(wr_pause == 1'b0, "R8 pause released", int'(wr_pause), 0);
    check(empty_n == 1'b0, "R8 empty flag", int'(empty_n), 0);
    check(in_ready == 1'b1, "R8 ready again", int'(in_ready), 1);
    check(tx == 1'b1, "R6 idle line", int'(tx), 1);
  endtask

  task automatic fill_full(input int pat, input bit push_paused);
    rx_cnt = 0;
    exp_cnt = 0;
    for (int i = 0; i < DEP; i++) begin
      put(DW'((pat * 53 + i * 29 + 7) & 255));
      if (i == 0)
        check(empty_n == 1'b1, "R2 empty flag clears", int'(empty_n), 1);
    end
    check(full_n == 1'b0, "R3 full flag", int'(full_n), 0);
    check(in_ready == 1'b0, "R3 ready low when full", int'(in_ready), 0);
    @(negedge clk);
    check(wr_pause == 1'b1, "R3 pause after full", int'(wr_pause), 1);
    if (push_paused) begin
      in_valid = 1'b1;
      in_data  = 8'hEE;
      while (wr_pause) begin
        check(in_ready == 1'b0, "R5 ready low while paused", int'(in_ready), 0);
        @(negedge clk);
      end
      in_valid = 1'b0;
    end
    wait_frames(DEP);
    compare_all();
    expect_drained();
    if (push_paused)
      check(rx_cnt == DEP, "R5 paused bytes not sent", rx_cnt, DEP);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tx == 1'b1, "R1 tx idle", int'(tx), 1);
    check(empty_n == 1'b0, "R1 empty", int'(empty_n), 0);
    check(full_n == 1'b1, "R1 not full", int'(full_n), 1);
    check(wr_pause == 1'b0, "R1 no pause", int'(wr_pause), 0);
    check(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    fill_full(1, 1'b0);
    fill_full(2, 1'b1);
    fill_full(3, 1'b0);

    // Partial fills at every level below the depth, then flush.
    for (int k = 1; k < DEP; k++) begin
      rx_cnt = 0;
      exp_cnt = 0;
      for (int i = 0; i < k; i++) put(DW'((k * 37 + i * 11) & 255));
      check(empty_n == 1'b1, "R2 stored partial", int'(empty_n), 1);
      repeat (2 * FRAME) begin
        @(negedge clk);
        if (wr_pause || tx == 1'b0) break;
      end
      check(wr_pause == 1'b0, "R4 no drain without full", int'(wr_pause), 0);
      check(rx_cnt == 0 && tx == 1'b1, "R4 line quiet", rx_cnt, 0);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      check(wr_pause == 1'b1, "R9 flush starts drain", int'(wr_pause), 1);
      wait_frames(k);
      compare_all();
      expect_drained();
    end

    // Flush on an empty buffer.
    rx_cnt = 0;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check(wr_pause == 1'b0, "R9 flush when empty", int'(wr_pause), 0);
    repeat (2 * FRAME) @(negedge clk);
    check(rx_cnt == 0, "R9 nothing sent on empty flush", rx_cnt, 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule